// File: doc/BRIEF.md
# Cache-Control Effective Address Generator

This block forms the byte address that a cache-control operation acts on. From a 32-bit base register value, an optional upper 32-bit register for the wide form, the base register's index, and a signed immediate offset, it computes the target address. It also tags the address with the cache hierarchy it belongs to: data, constant, instruction or the local data window.

Two forms are supported:
- **Global form.** Uses a 32-bit signed offset. It can run in narrow mode, with a 32-bit sum zero-extended to 40 bits, or in wide mode, with a 64-bit sum.
- **Local form.** Uses a 24-bit signed offset. Its result always lies in the 32-bit local window.

If the base index names the zero register, or is outside the thread's register allocation, the immediate is used as an absolute address. Constant-hierarchy addresses carry the bank slot above bit 16. The cache-line index is reported with the address.

The result is registered. A two-state controller holds ST_IDLE while no request is present. A request (transition T_ACCEPT) moves it to ST_EMIT, where `valid_o` is high for the captured result. Another request keeps it in ST_EMIT (T_STREAM). With no request it returns to ST_IDLE (T_DRAIN). Reset forces ST_IDLE.

Top module: `cea_top`

## Requirements
- R1: `valid_o` is high in the cycle after each cycle with `req_i` high, and low in the cycle after each cycle with `req_i` low. Reset clears it.
- R2: Global narrow mode (`ext_i`=0, not fallback, data or instruction space): `addr_o` = (`base_lo_i` + `imm_i`) mod 2^32. Bits 63:40 are always zero in narrow mode.
- R3: Global wide mode (`ext_i`=1, not fallback): `addr_o` = ({`base_hi_i`,`base_lo_i`} + sign-extended `imm_i`) mod 2^64.
- R4: Fallback occurs when `reg_idx_i` equals all ones (255, the zero register) or `reg_idx_i` >= `reg_count_i`. In fallback the offset is the zero-extended immediate and both base inputs are ignored. The immediate is `imm_i` in the global form and `imm_i[23:0]` in the local form.
- R5: Local form (`local_i`=1):
  - The offset is `imm_i[23:0]` sign-extended, and `imm_i[31:24]` is ignored.
  - `ext_i`, `space_i` and `slot_i` are ignored.
  - The sum wraps at 2^32, so `addr_o[63:32]` is zero.
  - `space_o` = 3.
- R6: Global form with `space_i`=1 (constant): `addr_o` = offset + (`slot_i` << 16), where `slot_i` is 5 bits. In narrow mode the result is kept to 40 bits.
- R7: `line_o` = `addr_o` >> 7, for 128-byte lines.
- R8: Global form: `space_o` = `space_i`, encoded 0 data, 1 constant, 2 instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; operands sampled in this cycle |
| local_i | input | 1 | 1 selects the local form (24-bit offset) |
| ext_i | input | 1 | 1 selects the 64-bit wide global mode |
| space_i | input | 2 | Global hierarchy: 0 data, 1 constant, 2 instruction |
| reg_idx_i | input | 8 | Base register index; 255 is the zero register |
| reg_count_i | input | 9 | Registers allocated to the thread |
| base_lo_i | input | 32 | Base register value |
| base_hi_i | input | 32 | Upper register value for wide mode |
| imm_i | input | 32 | Signed byte offset, or the absolute address in fallback |
| slot_i | input | 5 | Constant bank slot |
| valid_o | output | 1 | Result valid |
| addr_o | output | 64 | Effective byte address |
| space_o | output | 2 | Space tag: 0 data, 1 constant, 2 instruction, 3 local |
| line_o | output | 57 | Cache-line index |

## Verification
The assertions take `space_i` to be one of the three global codes whenever `req_i` is high in the global form, and they treat `reg_count_i` as a plain unsigned count. The bench sweeps only legal space codes and drives counts between 6 and 256. Under those conditions it walks every combination of form, mode, space, register index class and immediate polarity, including the 32-bit wrap and the sign boundary of the 24-bit offset. Inputs change only at falling edges, and each result is read one falling edge after its request.

// File: rtl/cea_pkg.sv
package cea_pkg;
    typedef enum logic [1:0] {
        SPC_DATA  = 2'd0,
        SPC_CONST = 2'd1,
        SPC_INSTR = 2'd2,
        SPC_LOCAL = 2'd3
    } space_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned WIDE_W = 64;
    localparam int unsigned NARROW_W = 40;
    localparam int unsigned LOCAL_IMM_W = 24;
    localparam int unsigned SLOT_SHIFT = 16;
endpackage

// File: rtl/cea_operand_sel.sv
module cea_operand_sel
    import cea_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                 local_i,
    input  logic                 ext_i,
    input  logic [IDX_W-1:0]     reg_idx_i,
    input  logic [IDX_W:0]       reg_count_i,
    input  logic [WORD_W-1:0]    base_lo_i,
    input  logic [WORD_W-1:0]    base_hi_i,
    input  logic [WORD_W-1:0]    imm_i,
    output logic [WIDE_W-1:0]    op_a_o,
    output logic [WIDE_W-1:0]    op_b_o,
    output logic                 wide_o
);
    localparam logic [IDX_W-1:0] ZERO_REG = '1;

    logic                 fallback;
    logic [WORD_W-1:0]    imm_local_sx;
    logic [WORD_W-1:0]    imm_local_zx;

    always_comb begin
        fallback     = (reg_idx_i == ZERO_REG) || ({1'b0, reg_idx_i} >= reg_count_i);
        imm_local_sx = {{(WORD_W-LOCAL_IMM_W){imm_i[LOCAL_IMM_W-1]}}, imm_i[LOCAL_IMM_W-1:0]};
        imm_local_zx = {{(WORD_W-LOCAL_IMM_W){1'b0}}, imm_i[LOCAL_IMM_W-1:0]};
        wide_o       = ext_i && !local_i;

        if (fallback) begin
            op_a_o = '0;
            op_b_o = {{(WIDE_W-WORD_W){1'b0}}, (local_i ? imm_local_zx : imm_i)};
        end else if (local_i) begin
            op_a_o = {{(WIDE_W-WORD_W){1'b0}}, base_lo_i};
            op_b_o = {{(WIDE_W-WORD_W){1'b0}}, imm_local_sx};
        end else if (ext_i) begin
            op_a_o = {base_hi_i, base_lo_i};
            op_b_o = {{(WIDE_W-WORD_W){imm_i[WORD_W-1]}}, imm_i};
        end else begin
            op_a_o = {{(WIDE_W-WORD_W){1'b0}}, base_lo_i};
            op_b_o = {{(WIDE_W-WORD_W){1'b0}}, imm_i};
        end
    end
endmodule

// File: rtl/cea_adder.sv
module cea_adder
    import cea_pkg::*;
(
    input  logic [WIDE_W-1:0] op_a_i,
    input  logic [WIDE_W-1:0] op_b_i,
    input  logic              wide_i,
    output logic [WIDE_W-1:0] sum_o
);
    logic [WIDE_W-1:0] full;

    always_comb begin
        full  = op_a_i + op_b_i;
        sum_o = wide_i ? full : {{(WIDE_W-WORD_W){1'b0}}, full[WORD_W-1:0]};
    end
endmodule

// File: rtl/cea_space_pack.sv
module cea_space_pack
    import cea_pkg::*;
#(
    parameter int unsigned SLOT_W    = 5,
    parameter int unsigned LINE_BITS = 7
) (
    input  logic [WIDE_W-1:0]           off_i,
    input  logic                        const_en_i,
    input  logic                        wide_i,
    input  logic [SLOT_W-1:0]           slot_i,
    output logic [WIDE_W-1:0]           addr_o,
    output logic [WIDE_W-LINE_BITS-1:0] line_o
);
    logic [WIDE_W-1:0] slot_term;
    logic [WIDE_W-1:0] packed_addr;

    always_comb begin
        slot_term   = const_en_i ? ({{(WIDE_W-SLOT_W){1'b0}}, slot_i} << SLOT_SHIFT) : '0;
        packed_addr = off_i + slot_term;
        addr_o      = wide_i ? packed_addr
                             : {{(WIDE_W-NARROW_W){1'b0}}, packed_addr[NARROW_W-1:0]};
    end

    generate
        if (LINE_BITS == 0) begin : g_byte_lines
            assign line_o = addr_o;
        end else begin : g_wide_lines
            assign line_o = addr_o[WIDE_W-1:LINE_BITS];
        end
    endgenerate
endmodule

// File: rtl/cea_top.sv
module cea_top
    import cea_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned SLOT_W     = 5,
    parameter int unsigned LINE_BYTES = 128
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   req_i,
    input  logic                                   local_i,
    input  logic                                   ext_i,
    input  logic [1:0]                             space_i,
    input  logic [IDX_W-1:0]                       reg_idx_i,
    input  logic [IDX_W:0]                         reg_count_i,
    input  logic [31:0]                            base_lo_i,
    input  logic [31:0]                            base_hi_i,
    input  logic [31:0]                            imm_i,
    input  logic [SLOT_W-1:0]                      slot_i,
    output logic                                   valid_o,
    output logic [63:0]                            addr_o,
    output logic [1:0]                             space_o,
    output logic [64-$clog2(LINE_BYTES)-1:0]       line_o
);
    localparam int unsigned LINE_BITS = $clog2(LINE_BYTES);

    state_e                      state_q, state_d;
    logic [WIDE_W-1:0]           op_a, op_b, sum;
    logic                        wide;
    logic                        const_en;
    logic [WIDE_W-1:0]           addr_d;
    logic [WIDE_W-LINE_BITS-1:0] line_d;
    space_e                      space_d;

    cea_operand_sel #(.IDX_W(IDX_W)) u_sel (
        .local_i     (local_i),
        .ext_i       (ext_i),
        .reg_idx_i   (reg_idx_i),
        .reg_count_i (reg_count_i),
        .base_lo_i   (base_lo_i),
        .base_hi_i   (base_hi_i),
        .imm_i       (imm_i),
        .op_a_o      (op_a),
        .op_b_o      (op_b),
        .wide_o      (wide)
    );

    cea_adder u_add (
        .op_a_i (op_a),
        .op_b_i (op_b),
        .wide_i (wide),
        .sum_o  (sum)
    );

    assign const_en = !local_i && (space_i == SPC_CONST);
    assign space_d  = local_i ? SPC_LOCAL : space_e'(space_i);

    cea_space_pack #(.SLOT_W(SLOT_W), .LINE_BITS(LINE_BITS)) u_pack (
        .off_i      (sum),
        .const_en_i (const_en),
        .wide_i     (wide),
        .slot_i     (slot_i),
        .addr_o     (addr_d),
        .line_o     (line_d)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            line_o  <= '0;
            space_o <= SPC_DATA;
        end else if (req_i) begin
            addr_o  <= addr_d;
            line_o  <= line_d;
            space_o <= space_d;
        end
    end

    assign valid_o = (state_q == ST_EMIT);
endmodule

// File: rtl/cea_checker.sv
module cea_checker #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic             local_i,
    input logic             ext_i,
    input logic [1:0]       space_i,
    input logic [IDX_W-1:0] reg_idx_i,
    input logic [IDX_W:0]   reg_count_i,
    input logic [31:0]      imm_i,
    input logic             valid_o,
    input logic [63:0]      addr_o,
    input logic [1:0]       space_o
);
    p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    p_quiet_after_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    p_narrow_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !ext_i) |=> (addr_o[63:40] == 24'd0));

    p_absolute_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !local_i && space_i != 2'd1 &&
         (reg_idx_i == '1 || {1'b0, reg_idx_i} >= reg_count_i))
        |=> (addr_o == {32'd0, $past(imm_i)}));

    p_local_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && local_i) |=> (space_o == 2'd3 && addr_o[63:32] == 32'd0));

    p_space_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !local_i) |=> (space_o == $past(space_i)));
endmodule

bind cea_top cea_checker #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .local_i     (local_i),
    .ext_i       (ext_i),
    .space_i     (space_i),
    .reg_idx_i   (reg_idx_i),
    .reg_count_i (reg_count_i),
    .imm_i       (imm_i),
    .valid_o     (valid_o),
    .addr_o      (addr_o),
    .space_o     (space_o)
);

// File: tb/cea_top_tb.sv
module cea_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, local_i = 1'b0, ext_i = 1'b0;
    logic [1:0]  space_i = 2'd0;
    logic [7:0]  reg_idx_i = 8'd0;
    logic [8:0]  reg_count_i = 9'd6;
    logic [31:0] base_lo_i = '0, base_hi_i = '0, imm_i = '0;
    logic [4:0]  slot_i = '0;
    logic        valid_o;
    logic [63:0] addr_o;
    logic [1:0]  space_o;
    logic [56:0] line_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cea_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .local_i(local_i), .ext_i(ext_i),
        .space_i(space_i), .reg_idx_i(reg_idx_i), .reg_count_i(reg_count_i),
        .base_lo_i(base_lo_i), .base_hi_i(base_hi_i), .imm_i(imm_i), .slot_i(slot_i),
        .valid_o(valid_o), .addr_o(addr_o), .space_o(space_o), .line_o(line_o)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input bit loc, input bit ext, input logic [1:0] sp,
                                          input logic [7:0] idx, input logic [8:0] cnt,
                                          input logic [31:0] lo, input logic [31:0] hi,
                                          input logic [31:0] imm, input logic [4:0] slot);
        bit fb;
        logic [63:0] off;
        logic [31:0] s32;
        fb = (idx == 8'hFF) || (idx >= cnt);
        if (loc) begin
            if (fb) off = {40'd0, imm[23:0]};
            else begin
                s32 = lo + {{8{imm[23]}}, imm[23:0]};
                off = {32'd0, s32};
            end
            return off;
        end
        if (fb) off = {32'd0, imm};
        else if (ext) off = {hi, lo} + {{32{imm[31]}}, imm};
        else begin
            s32 = lo + imm;
            off = {32'd0, s32};
        end
        if (sp == 2'd1) off = off + ({59'd0, slot} * 64'd65536);
        if (!ext) off = off & 64'h0000_00FF_FFFF_FFFF;
        return off;
    endfunction

    function automatic string tag_of(input bit loc, input bit ext, input logic [1:0] sp, input bit fb);
        if (fb) return "R4 fallback address";
        if (loc) return "R5 local address";
        if (sp == 2'd1) return "R6 constant packing";
        if (ext) return "R3 wide address";
        return "R2 narrow address";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  idx_set [6];
        logic [31:0] imm_set [6];
        logic [31:0] lo_set  [2];
        logic [63:0] exp_addr;
        logic [1:0]  exp_sp;
        bit          fb;
        idx_set = '{8'd0, 8'd1, 8'd5, 8'd6, 8'd200, 8'hFF};
        imm_set = '{32'd0, 32'd4, 32'hFFFF_FFFC, 32'h7FFF_FFFF, 32'h0080_0000, 32'hFF00_0010};
        lo_set  = '{32'hFFFF_FFF0, 32'h0000_0003};

        repeat (3) @(negedge clk);
        check64("R1 reset valid", {63'd0, valid_o}, 64'd0);
        check64("R1 reset addr", addr_o, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1 idle valid", {63'd0, valid_o}, 64'd0);

        for (int l = 0; l < 2; l++)
        for (int e = 0; e < 2; e++)
        for (int s = 0; s < 3; s++)
        for (int i = 0; i < 6; i++)
        for (int m = 0; m < 6; m++)
        for (int b = 0; b < 2; b++) begin
            req_i       = 1'b1;
            local_i     = l[0];
            ext_i       = e[0];
            space_i     = s[1:0];
            reg_idx_i   = idx_set[i];
            reg_count_i = (b == 0) ? 9'd6 : 9'd256;
            base_lo_i   = lo_set[b];
            base_hi_i   = (b == 0) ? 32'h0000_0001 : 32'hFFFF_FFFF;
            imm_i       = imm_set[m];
            slot_i      = (b == 0) ? 5'h1F : 5'h02;
            exp_addr = model(local_i, ext_i, space_i, reg_idx_i, reg_count_i,
                             base_lo_i, base_hi_i, imm_i, slot_i);
            fb = (reg_idx_i == 8'hFF) || ({1'b0, reg_idx_i} >= reg_count_i);
            exp_sp = l[0] ? 2'd3 : s[1:0];
            @(negedge clk);
            check64("R1 valid after request", {63'd0, valid_o}, 64'd1);
            check64(tag_of(l[0], e[0], s[1:0], fb), addr_o, exp_addr);
            check64("R7 line index", {7'd0, line_o}, exp_addr >> 7);
            check64(l[0] ? "R5 local tag" : "R8 space tag", {62'd0, space_o}, {62'd0, exp_sp});
        end

        req_i = 1'b0;
        @(negedge clk);
        check64("R1 valid drops", {63'd0, valid_o}, 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule